// File: doc/BRIEF.md
# Fast Ethernet Controller Control and Interrupt Registers

This block is the register front end of a 10/100 Ethernet controller. It holds a control word with three live fields: an enable, a self-timed local soft reset and a transmit-retime mode. It also holds a sticky event register, an event mask and the single interrupt line they combine into. A host reads and writes these registers over a plain synchronous word-addressed port. Reads are combinational from the current register state. Writes take effect at the next clock edge.

From the control state the block drives the levels and strobes that the rest of the controller obeys. It sends an enable to the receive and transmit paths and holds the DMA, descriptor and FIFO logic in reset while the controller is off. When the controller is switched off in the middle of a transmit frame, it pulses a request to end that frame with a bad CRC. While a soft reset runs, it asserts an abrupt-abort level. On the transmit side of the MII, a small retiming stage can present the nibble, enable and error outputs half a transmit-clock period late. This helps with PHYs whose hold-time needs exceed the usual budget.

Top module: `emac_ctrl_regs`

## Requirements
- R1: After reset, all three registers read zero, `rx_en`, `tx_en`, `irq`, `tx_bad_crc` and `hard_abort` are low, and `dma_fifo_rst` is high.
- R2: A write to word 0 loads the enable from bit 1 and the retime mode from bit 25. A read of word 0 returns them in the same positions. Every other bit of word 0 reads zero, except bit 0 during a soft reset (R6).
- R3: The edge that writes a zero to the enable bit drops `rx_en` and `tx_en`, and it raises `dma_fifo_rst`. `dma_fifo_rst` stays high while the enable is zero.
- R4: If `tx_busy` is high when a write clears a set enable, `tx_bad_crc` is high for exactly the one cycle after that edge. If `tx_busy` is low, no pulse occurs.
- R5: A write of a one to bit 0 of word 0 starts a soft reset. At that edge, the enable, the retime mode, the mask and all event bits return to zero. `hard_abort` is then high for the length of the soft reset, and events that arrive during it are dropped.
- R6: Bit 0 of word 0 reads one for exactly SR_CYCLES cycles after the starting write and then returns to zero by itself.
- R7: While a soft reset runs, host writes to any register have no effect. After it ends, writes act normally again.
- R8: A one on bit i of `evt_in` in a cycle sets event bit i, which is read at bit i of word 1. The bit stays set until it is cleared.
- R9: Writing word 1 clears each event bit whose write-data bit is one. Write-data bits that are zero leave their event bits unchanged.
- R10: If the same event bit gets a hardware set and a write-one clear in the same cycle, the bit ends up set.
- R11: Word 2 holds the event mask, bit i for event i. `irq` is high exactly when some event bit and its mask bit are both set.
- R12: With retime off, `mii_txd`, `mii_txen` and `mii_txer` follow the MAC inputs directly. With retime on, they show the MAC inputs as sampled at the latest falling edge of `tx_clk`, and they hold that value until the next falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and control clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the host port |
| reg_addr | input | ADDR_W | Word address: 0 control, 1 events, 2 mask |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr` |
| evt_in | input | NUM_EVT | One-cycle event set pulses from the controller |
| irq | output | 1 | Combined masked interrupt |
| tx_busy | input | 1 | Transmit path is sending a frame |
| rx_en | output | 1 | Receive path enable |
| tx_en | output | 1 | Transmit path enable |
| tx_bad_crc | output | 1 | Pulse: end the current frame with a bad CRC |
| dma_fifo_rst | output | 1 | Reset level for DMA, descriptor and FIFO control |
| hard_abort | output | 1 | Abrupt abort of all traffic during soft reset |
| tx_clk | input | 1 | MII transmit clock |
| mac_txd | input | 4 | Transmit nibble from the MAC |
| mac_txen | input | 1 | Transmit enable from the MAC |
| mac_txer | input | 1 | Transmit error from the MAC |
| mii_txd | output | 4 | Transmit nibble toward the PHY |
| mii_txen | output | 1 | Transmit enable toward the PHY |
| mii_txer | output | 1 | Transmit error toward the PHY |

## Verification
The bench builds the block with SR_CYCLES set to 6, NUM_EVT set to 8 and ADDR_W set to 4. The short soft-reset window lets the bench count every cycle in which bit 0 reads one and compare the count with the exact limit. It also leaves room to try a write and an event inside the window. Eight events cover all the combinations of sticky set, clear, mask and same-cycle set and clear with a one-byte pattern. The upper event bits exercise the vector ends.

// File: rtl/emac_ctrl_pkg.sv
package emac_ctrl_pkg;

    localparam int REG_W      = 32;

    // control word field positions (host-visible, fixed)
    localparam int BIT_SRST   = 0;
    localparam int BIT_EN     = 1;
    localparam int BIT_RETIME = 25;

    // word offsets on the host port
    localparam int OFS_CTRL   = 0;
    localparam int OFS_EVT    = 1;
    localparam int OFS_MASK   = 2;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_EVT  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic retime;
        logic en;
    } ctrl_fields_t;

    typedef struct packed {
        logic [3:0] d;
        logic       en;
        logic       er;
    } mii_tx_t;

    function automatic ctrl_fields_t unpack_ctrl(input logic [REG_W-1:0] w);
        ctrl_fields_t f;
        f.retime = w[BIT_RETIME];
        f.en     = w[BIT_EN];
        return f;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_fields_t f,
                                                   input logic busy);
        logic [REG_W-1:0] w;
        w             = '0;
        w[BIT_RETIME] = f.retime;
        w[BIT_EN]     = f.en;
        w[BIT_SRST]   = busy;
        return w;
    endfunction

endpackage

// File: rtl/emac_softrst_seq.sv
module emac_softrst_seq #(
    parameter int SR_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    output logic busy,
    output logic load
);
    localparam int CNT_W = $clog2(SR_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    assign busy = (cnt_q != '0);
    assign load = start_req & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(SR_CYCLES);
        end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/emac_ctl_field.sv
module emac_ctl_field
    import emac_ctrl_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         wr_ctrl,
    input  ctrl_fields_t wr_fields,
    input  logic         tx_busy,
    output ctrl_fields_t ctrl_q,
    output logic         tx_bad_crc
);
    logic en_falls;

    // enable taken down by an ordinary host write, not by the soft reset
    assign en_falls = wr_ctrl & ~clr & ctrl_q.en & ~wr_fields.en;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= wr_fields;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_bad_crc <= 1'b0;
        end else begin
            tx_bad_crc <= en_falls & tx_busy;
        end
    end
endmodule

// File: rtl/emac_evt_bank.sv
module emac_evt_bank #(
    parameter int NUM_EVT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               w1c_en,
    input  logic [NUM_EVT-1:0] w1c_bits,
    input  logic               mask_wr,
    input  logic [NUM_EVT-1:0] mask_wdata,
    output logic [NUM_EVT-1:0] evt_q,
    output logic [NUM_EVT-1:0] mask_q,
    output logic               irq
);
    for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                bit_q <= 1'b0;
            end else if (evt_in[i]) begin
                bit_q <= 1'b1;               // hardware set wins
            end else if (w1c_en && w1c_bits[i]) begin
                bit_q <= 1'b0;
            end
        end
        assign evt_q[i] = bit_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= mask_wdata;
        end
    end

    assign irq = |(evt_q & mask_q);
endmodule

// File: rtl/emac_tx_retime.sv
module emac_tx_retime
    import emac_ctrl_pkg::*;
(
    input  logic    tx_clk,
    input  logic    retime,
    input  mii_tx_t mac_tx,
    output mii_tx_t mii_tx
);
    mii_tx_t fall_q;

    always_ff @(negedge tx_clk) begin
        fall_q <= mac_tx;
    end

    assign mii_tx = retime ? fall_q : mac_tx;
endmodule

// File: rtl/emac_ctrl_regs.sv
module emac_ctrl_regs
    import emac_ctrl_pkg::*;
#(
    parameter int NUM_EVT   = 16,
    parameter int SR_CYCLES = 16,
    parameter int ADDR_W    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    output logic               irq,
    input  logic               tx_busy,
    output logic               rx_en,
    output logic               tx_en,
    output logic               tx_bad_crc,
    output logic               dma_fifo_rst,
    output logic               hard_abort,
    input  logic               tx_clk,
    input  logic [3:0]         mac_txd,
    input  logic               mac_txen,
    input  logic               mac_txer,
    output logic [3:0]         mii_txd,
    output logic               mii_txen,
    output logic               mii_txer
);
    reg_sel_e           sel;
    logic               sr_busy;
    logic               sr_load;
    logic               sr_clr;
    logic               wr_ctrl;
    ctrl_fields_t       ctrl_q;
    logic [NUM_EVT-1:0] evt_q;
    logic [NUM_EVT-1:0] mask_q;
    mii_tx_t            mac_tx;
    mii_tx_t            mii_tx;

    always_comb begin
        if (reg_addr == ADDR_W'(OFS_CTRL))      sel = SEL_CTRL;
        else if (reg_addr == ADDR_W'(OFS_EVT))  sel = SEL_EVT;
        else if (reg_addr == ADDR_W'(OFS_MASK)) sel = SEL_MASK;
        else                                    sel = SEL_NONE;
    end

    emac_softrst_seq #(.SR_CYCLES(SR_CYCLES)) u_srst (
        .clk       (clk),
        .rst       (rst),
        .start_req (reg_wr && sel == SEL_CTRL && reg_wdata[BIT_SRST]),
        .busy      (sr_busy),
        .load      (sr_load)
    );

    assign sr_clr  = sr_load | sr_busy;
    assign wr_ctrl = reg_wr && sel == SEL_CTRL && !sr_busy;

    emac_ctl_field u_ctl (
        .clk        (clk),
        .rst        (rst),
        .clr        (sr_clr),
        .wr_ctrl    (wr_ctrl),
        .wr_fields  (unpack_ctrl(reg_wdata)),
        .tx_busy    (tx_busy),
        .ctrl_q     (ctrl_q),
        .tx_bad_crc (tx_bad_crc)
    );

    emac_evt_bank #(.NUM_EVT(NUM_EVT)) u_evt (
        .clk        (clk),
        .rst        (rst),
        .clr        (sr_clr),
        .evt_in     (evt_in),
        .w1c_en     (reg_wr && sel == SEL_EVT && !sr_busy),
        .w1c_bits   (reg_wdata[NUM_EVT-1:0]),
        .mask_wr    (reg_wr && sel == SEL_MASK && !sr_busy),
        .mask_wdata (reg_wdata[NUM_EVT-1:0]),
        .evt_q      (evt_q),
        .mask_q     (mask_q),
        .irq        (irq)
    );

    always_comb begin
        unique case (sel)
            SEL_CTRL: reg_rdata = pack_ctrl(ctrl_q, sr_busy);
            SEL_EVT:  reg_rdata = REG_W'(evt_q);
            SEL_MASK: reg_rdata = REG_W'(mask_q);
            default:  reg_rdata = '0;
        endcase
    end

    assign rx_en        = ctrl_q.en;
    assign tx_en        = ctrl_q.en;
    assign dma_fifo_rst = ~ctrl_q.en;
    assign hard_abort   = sr_busy;

    assign mac_tx = '{d: mac_txd, en: mac_txen, er: mac_txer};

    emac_tx_retime u_rt (
        .tx_clk (tx_clk),
        .retime (ctrl_q.retime),
        .mac_tx (mac_tx),
        .mii_tx (mii_tx)
    );

    assign mii_txd  = mii_tx.d;
    assign mii_txen = mii_tx.en;
    assign mii_txer = mii_tx.er;
endmodule

// File: rtl/emac_ctrl_regs_chk.sv
module emac_ctrl_regs_chk #(
    parameter int NUM_EVT   = 16,
    parameter int SR_CYCLES = 16,
    parameter int ADDR_W    = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [31:0]        reg_rdata,
    input logic [NUM_EVT-1:0] evt_in,
    input logic [NUM_EVT-1:0] evt_q,
    input logic [NUM_EVT-1:0] mask_q,
    input logic               sr_clr,
    input logic               irq,
    input logic               rx_en,
    input logic               tx_bad_crc,
    input logic               hard_abort
);
    localparam int RUN_W = $clog2(SR_CYCLES + 2) + 1;

    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)             busy_run <= '0;
        else if (hard_abort) busy_run <= busy_run + 1'b1;
        else                 busy_run <= '0;
    end

    AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);                                        // R11
    AST_EVT_NOT_LOST: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sr_clr)) |-> ((evt_q & $past(evt_in)) == $past(evt_in))); // R10
    AST_SR_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
        hard_abort |-> !rx_en);                                          // R5
    AST_SR_BIT_READ: assert property (@(posedge clk) disable iff (rst)
        (hard_abort && reg_addr == '0) |-> reg_rdata[0]);                // R6
    AST_SR_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        busy_run <= RUN_W'(SR_CYCLES));                                  // R6
    AST_SR_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hard_abort)) |-> (mask_q == '0));          // R7
    AST_BADCRC_PULSE: assert property (@(posedge clk) disable iff (rst)
        tx_bad_crc |=> !tx_bad_crc);                                     // R4
    AST_BADCRC_DISABLED: assert property (@(posedge clk) disable iff (rst)
        tx_bad_crc |-> !rx_en);                                          // R3
endmodule

bind emac_ctrl_regs emac_ctrl_regs_chk #(
    .NUM_EVT   (NUM_EVT),
    .SR_CYCLES (SR_CYCLES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .evt_in     (evt_in),
    .evt_q      (evt_q),
    .mask_q     (mask_q),
    .sr_clr     (sr_clr),
    .irq        (irq),
    .rx_en      (rx_en),
    .tx_bad_crc (tx_bad_crc),
    .hard_abort (hard_abort)
);

// File: tb/test_emac_ctrl_regs.sv
`timescale 1ns/100ps
module test_emac_ctrl_regs;
    localparam int NE = 8;
    localparam int SRC = 6;

    logic        clk = 1'b0, rst = 1'b1, reg_wr = 1'b0, tx_busy = 1'b0, tx_clk = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic [NE-1:0] evt_in = '0;
    logic irq, rx_en, tx_en, tx_bad_crc, dma_fifo_rst, hard_abort;
    logic [3:0] mac_txd = '0, mii_txd;
    logic mac_txen = 1'b0, mac_txer = 1'b0, mii_txen, mii_txer;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2  clk    = ~clk;
    always #10 tx_clk = ~tx_clk;

    emac_ctrl_regs #(.NUM_EVT(NE), .SR_CYCLES(SRC), .ADDR_W(4)) i_emac_ctrl_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in), .irq(irq),
        .tx_busy(tx_busy), .rx_en(rx_en), .tx_en(tx_en), .tx_bad_crc(tx_bad_crc),
        .dma_fifo_rst(dma_fifo_rst), .hard_abort(hard_abort), .tx_clk(tx_clk),
        .mac_txd(mac_txd), .mac_txen(mac_txen), .mac_txer(mac_txer),
        .mii_txd(mii_txd), .mii_txen(mii_txen), .mii_txer(mii_txer));

    typedef struct packed {
        logic        wr;
        logic [3:0]  addr;
        logic [31:0] wdata;
        logic [7:0]  evt;
        logic [3:0]  raddr;
        logic [31:0] exp;
        logic        exp_irq;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{1'b1, 4'd0, 32'h0200_0002, 8'h00, 4'd0, 32'h0200_0002, 1'b0}, // R2 enable+retime
        '{1'b1, 4'd0, 32'hFFFF_FFFE, 8'h00, 4'd0, 32'h0200_0002, 1'b0}, // R2 reserved read zero
        '{1'b0, 4'd0, 32'h0,         8'h05, 4'd1, 32'h0000_0005, 1'b0}, // R8 sticky set
        '{1'b1, 4'd2, 32'h0000_0004, 8'h00, 4'd2, 32'h0000_0004, 1'b1}, // R11 mask
        '{1'b1, 4'd1, 32'h0000_0000, 8'h00, 4'd1, 32'h0000_0005, 1'b1}, // R9 zero no effect
        '{1'b1, 4'd1, 32'h0000_0004, 8'h00, 4'd1, 32'h0000_0001, 1'b0}, // R9 clear one
        '{1'b1, 4'd1, 32'h0000_0001, 8'h01, 4'd1, 32'h0000_0001, 1'b0}, // R10 set wins
        '{1'b1, 4'd1, 32'h0000_0001, 8'h80, 4'd1, 32'h0000_0080, 1'b0}, // R8 R9 top bit
        '{1'b1, 4'd2, 32'h0000_00FF, 8'h00, 4'd2, 32'h0000_00FF, 1'b1}, // R11 full mask
        '{1'b1, 4'd1, 32'h0000_00FF, 8'h00, 4'd1, 32'h0000_0000, 1'b0}  // R9 R11 clear all
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [3:0] addr, input logic [31:0] wd,
                        input logic [NE-1:0] ev, input logic [3:0] raddr);
        @(negedge clk);
        reg_wr = wr; reg_addr = addr; reg_wdata = wd; evt_in = ev;
        @(posedge clk);
        #0.5;
        reg_wr = 1'b0; evt_in = '0; reg_addr = raddr;
        #0.5;
    endtask

    initial begin
        #400000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int busy_n;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #0.5;
        // R1 reset state
        reg_addr = 4'd0; #0.1; check("R1 ctrl", reg_rdata, 32'h0);
        reg_addr = 4'd1; #0.1; check("R1 evt",  reg_rdata, 32'h0);
        reg_addr = 4'd2; #0.1; check("R1 mask", reg_rdata, 32'h0);
        check("R1 outs", {rx_en, tx_en, irq, tx_bad_crc, hard_abort, dma_fifo_rst}, 32'h1);

        for (int i = 0; i < 10; i++) begin
            step(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].evt, VECS[i].raddr);
            check($sformatf("vec%0d rdata (R2/R8/R9/R10/R11)", i), reg_rdata, VECS[i].exp);
            check($sformatf("vec%0d irq R11", i), irq, VECS[i].exp_irq);
        end

        // R3 R4: disable during a transmit frame
        step(1'b1, 4'd0, 32'h2, '0, 4'd0);
        tx_busy = 1'b1;
        step(1'b1, 4'd0, 32'h0, '0, 4'd0);
        check("R3 rx/tx off, fifo rst", {rx_en, tx_en, dma_fifo_rst}, 32'h1);
        check("R4 bad crc pulse", tx_bad_crc, 1);
        step(1'b0, 4'd0, 32'h0, '0, 4'd0);
        check("R4 pulse one cycle", tx_bad_crc, 0);
        check("R3 fifo rst holds", dma_fifo_rst, 1);
        tx_busy = 1'b0;
        step(1'b1, 4'd0, 32'h2, '0, 4'd0);
        check("R3 enabled", {rx_en, tx_en, dma_fifo_rst}, 32'h6);
        step(1'b1, 4'd0, 32'h0, '0, 4'd0);
        check("R4 no pulse when idle", tx_bad_crc, 0);

        // R5 R6 R7 soft reset
        step(1'b1, 4'd0, 32'h0200_0002, '0, 4'd0);
        step(1'b1, 4'd2, 32'hFF, 8'h03, 4'd0);
        check("R11 irq before srst", irq, 1);
        step(1'b1, 4'd0, 32'h0000_0001, '0, 4'd0);
        busy_n = reg_rdata[0] ? 1 : 0;
        check("R5 ctrl cleared, bit0 busy", reg_rdata, 32'h1);
        check("R5 abort, rx off, irq off", {hard_abort, rx_en, irq}, 32'h4);
        step(1'b1, 4'd0, 32'h0000_0002, 8'h10, 4'd0);
        busy_n += reg_rdata[0] ? 1 : 0;
        check("R7 write ignored", reg_rdata, 32'h1);
        step(1'b1, 4'd2, 32'h0000_00AA, '0, 4'd2);
        busy_n += hard_abort ? 1 : 0;
        check("R7 mask write ignored", reg_rdata, 32'h0);
        reg_addr = 4'd1; #0.1;
        check("R5 events cleared and dropped", reg_rdata, 32'h0);
        reg_addr = 4'd0; #0.1;
        for (int g = 0; g < 40 && reg_rdata[0]; g++) begin
            step(1'b0, 4'd0, 32'h0, '0, 4'd0);
            if (reg_rdata[0]) busy_n++;
        end
        check("R6 busy length", busy_n, SRC);
        check("R6 self clear", {hard_abort, reg_rdata[0]}, 32'h0);
        step(1'b1, 4'd0, 32'h2, '0, 4'd0);
        check("R7 writes resume", reg_rdata, 32'h2);

        // R12 retime
        step(1'b1, 4'd0, 32'h0200_0000, '0, 4'd0);
        @(posedge tx_clk); #1;
        mac_txd = 4'hA; mac_txen = 1'b1; mac_txer = 1'b1; #1;
        check("R12 delayed before fall", {mii_txd, mii_txen, mii_txer}, 32'h0);
        @(negedge tx_clk); #1;
        check("R12 captured at fall", {mii_txd, mii_txen, mii_txer}, {26'h0, 4'hA, 2'b11});
        mac_txd = 4'h5; mac_txer = 1'b0; #1;
        check("R12 held", {mii_txd, mii_txen, mii_txer}, {26'h0, 4'hA, 2'b11});
        @(negedge tx_clk); #1;
        check("R12 next fall", {mii_txd, mii_txen, mii_txer}, {26'h0, 4'h5, 2'b10});
        step(1'b1, 4'd0, 32'h0, '0, 4'd0);
        mac_txd = 4'h3; #0.1;
        check("R12 direct path", {mii_txd, mii_txen, mii_txer}, {26'h0, 4'h3, 2'b10});

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule